// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block sits beside a processor core and decides when one of two asynchronous hardware interrupt sources may be taken. The first source is a timer countdown event. It is edge-triggered and coalescing: a rising edge leaves a sticky pending flag. The second source is an external request line. It is level-triggered and never latched, so it counts only while the line is high.

A single interrupt-enable bit, held inside the block, gates delivery of both sources. The core loads that bit through a status-write strobe, and the block re-evaluates delivery in the same cycle. When delivery is allowed, the block raises a take-interrupt request together with a cause code and holds both until the core acknowledges. On acknowledge the enable bit drops to zero, as the core does on interrupt entry, and a delivered timer flag is cleared.

Top module: `irq_gate_ctrl`

## Requirements
- R1: A 0-to-1 transition of `dec_evt` between two consecutive clock samples sets `pend[1]` at that edge. The flag stays set until a timer delivery is acknowledged.
- R2: Any number of timer edges that arrive before delivery produce exactly one request with cause 2'b10. After that request is acknowledged, setting the enable bit again produces no further request.
- R3: `pend[0]` follows `ext_lvl` directly. An external request is raised only when `ext_lvl` is high in a cycle where the enable bit is set and no request is outstanding.
- R4: If `ext_lvl` goes high and then low while the enable bit is clear, no request is ever raised for that pulse.
- R5: A cycle with `stat_wr` high loads `stat_en` into the enable bit. Delivery uses the newly written value in that same cycle, so `take_req` rises at the next clock edge. Writing 0 prevents any request at that edge.
- R6: The cause code is 2'b01 for external, 2'b10 for timer and 2'b00 while no request is outstanding. When both sources are ready at once, external is chosen and the timer stays pending.
- R7: `take_req` and `cause` stay unchanged from the edge where the request rises until the edge after `ack` is sampled high, even if `ext_lvl` falls in between.
- R8: An acknowledged request drops `take_req` and forces the enable bit to 0, overriding a status write in the same cycle. If the cause was timer, `pend[1]` is cleared unless a new timer edge arrives in that cycle.
- R9: `ack` while no request is outstanding has no effect on `pend` or on later delivery.
- R10: A synchronous active-high `rst` clears the timer flag, the enable bit, `take_req` and `cause`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_evt | input | 1 | Timer event; its rising edge marks a request |
| ext_lvl | input | 1 | External request level |
| stat_wr | input | 1 | Status-write strobe for the enable bit |
| stat_en | input | 1 | Enable value loaded when `stat_wr` is high |
| ack | input | 1 | Core accepts the outstanding request |
| pend | output | 2 | Bit 0 external level, bit 1 sticky timer flag |
| take_req | output | 1 | Take-interrupt request |
| cause | output | 2 | Cause of the outstanding request |

## Verification
The delivery decision is exercised with several stimulus patterns, and each one separates two alternative behaviours:
- A short external pulse while masked is followed by an enable write. This shows whether the level is wrongly latched.
- A burst of timer pulses while masked shows whether edges are counted instead of coalesced.
- Both sources pending when the enable bit is written tests the priority order and confirms that the timer flag survives the external delivery.
- An acknowledge with no request outstanding must leave the state unchanged.
- An acknowledge that coincides with an enable write shows whether the forced clear of the enable bit takes precedence.
- A reset in the middle of a run shows whether pending state survives reset.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_EXT  = 2'b01,
        CAUSE_DEC  = 2'b10
    } cause_e;

    typedef struct packed {
        logic   en;
        logic   take;
        cause_e cause;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{en: 1'b0, take: 1'b0, cause: CAUSE_NONE};

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output logic pend,
    output logic hit
);
    logic prev_d, prev_q;
    logic flag_d, flag_q;
    logic rise;

    always_comb begin
        rise   = evt & ~prev_q;
        prev_d = evt;
        flag_d = (flag_q & ~clr) | rise;
        hit    = flag_q | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            flag_q <= flag_d;
        end
    end

    assign pend = flag_q;
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_gate_pkg::*;
#(
    parameter bit EXT_FIRST = 1'b1
) (
    input  logic   ext_req,
    input  logic   dec_req,
    output cause_e pick
);
    generate
        if (EXT_FIRST) begin : g_ext_first
            always_comb begin
                if (ext_req)      pick = CAUSE_EXT;
                else if (dec_req) pick = CAUSE_DEC;
                else              pick = CAUSE_NONE;
            end
        end else begin : g_dec_first
            always_comb begin
                if (dec_req)      pick = CAUSE_DEC;
                else if (ext_req) pick = CAUSE_EXT;
                else              pick = CAUSE_NONE;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_gate_pkg::*;
#(
    parameter bit EXT_FIRST = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dec_evt,
    input  logic       ext_lvl,
    input  logic       stat_wr,
    input  logic       stat_en,
    input  logic       ack,
    output logic [1:0] pend,
    output logic       take_req,
    output logic [1:0] cause
);
    ctl_s   st_d, st_q;
    logic   dec_pend, dec_hit, dec_clr;
    logic   en_next;
    cause_e pick;

    irq_edge_latch u_dec (
        .clk  (clk),
        .rst  (rst),
        .evt  (dec_evt),
        .clr  (dec_clr),
        .pend (dec_pend),
        .hit  (dec_hit)
    );

    irq_select #(.EXT_FIRST(EXT_FIRST)) u_sel (
        .ext_req (ext_lvl),
        .dec_req (dec_hit),
        .pick    (pick)
    );

    always_comb begin
        st_d    = st_q;
        dec_clr = 1'b0;
        en_next = stat_wr ? stat_en : st_q.en;
        if (st_q.take) begin
            if (ack) begin
                st_d.take  = 1'b0;
                st_d.cause = CAUSE_NONE;
                st_d.en    = 1'b0;
                dec_clr    = (st_q.cause == CAUSE_DEC);
            end else begin
                st_d.en = en_next;
            end
        end else begin
            st_d.en = en_next;
            if (en_next && pick != CAUSE_NONE) begin
                st_d.take  = 1'b1;
                st_d.cause = pick;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CTL_RESET;
        else     st_q <= st_d;
    end

    assign pend     = {dec_pend, ext_lvl};
    assign take_req = st_q.take;
    assign cause    = st_q.cause;
endmodule

module irq_gate_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       dec_evt,
    input logic       ext_lvl,
    input logic       stat_wr,
    input logic       stat_en,
    input logic       ack,
    input logic [1:0] pend,
    input logic       take_req,
    input logic [1:0] cause
);
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (take_req && !ack) |=> (take_req && $stable(cause)));

    assert_cause_code_R6: assert property (@(posedge clk) disable iff (rst)
        take_req |-> ($countones(cause) == 1));

    assert_idle_cause_R6: assert property (@(posedge clk) disable iff (rst)
        !take_req |-> (cause == 2'b00));

    assert_ext_first_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(take_req) && $past(ext_lvl)) |-> (cause == 2'b01));

    assert_ack_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (take_req && ack) |=> !take_req);

    assert_dec_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (take_req && ack && cause == 2'b10 && !dec_evt) |=> !pend[1]);

    assert_dec_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        (pend[1] && !(take_req && ack)) |=> pend[1]);

    assert_masked_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!take_req && stat_wr && !stat_en) |=> !take_req);
endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dec_evt  (dec_evt),
    .ext_lvl  (ext_lvl),
    .stat_wr  (stat_wr),
    .stat_en  (stat_en),
    .ack      (ack),
    .pend     (pend),
    .take_req (take_req),
    .cause    (cause)
);

// File: tb/irq_gate_ctrl_test.sv
`timescale 1ns/1ps
module irq_gate_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_evt = 1'b0;
    logic       ext_lvl = 1'b0;
    logic       stat_wr = 1'b0;
    logic       stat_en = 1'b0;
    logic       ack = 1'b0;
    logic [1:0] pend;
    logic       take_req;
    logic [1:0] cause;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    irq_gate_ctrl uut (
        .clk(clk), .rst(rst), .dec_evt(dec_evt), .ext_lvl(ext_lvl),
        .stat_wr(stat_wr), .stat_en(stat_en), .ack(ack),
        .pend(pend), .take_req(take_req), .cause(cause)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_en(input logic v);
        stat_wr = 1'b1; stat_en = v;
        step(1);
        stat_wr = 1'b0; stat_en = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic dec_pulse();
        dec_evt = 1'b1; step(1);
        dec_evt = 1'b0; step(1);
    endtask

    task automatic t_reset();
        chk("R10 pend after reset", {2'b0, pend}, 4'h0);
        chk("R10 take after reset", {3'b0, take_req}, 4'h0);
        chk("R10 cause after reset", {2'b0, cause}, 4'h0);
    endtask

    task automatic t_masked_pulse();
        ext_lvl = 1'b1; step(2);
        chk("R3 pend0 follows level", {2'b0, pend}, 4'h1);
        chk("R4 no take while masked", {3'b0, take_req}, 4'h0);
        ext_lvl = 1'b0; step(1);
        write_en(1'b1);
        step(2);
        chk("R4 lost pulse never delivered", {3'b0, take_req}, 4'h0);
        write_en(1'b0);
    endtask

    task automatic t_ext_deliver();
        ext_lvl = 1'b1;
        write_en(1'b1);
        chk("R5 take one edge after write", {3'b0, take_req}, 4'h1);
        chk("R6 external cause", {2'b0, cause}, 4'h1);
        ext_lvl = 1'b0; step(2);
        chk("R7 take held after level drop", {3'b0, take_req}, 4'h1);
        chk("R7 cause held", {2'b0, cause}, 4'h1);
        do_ack();
        chk("R8 take dropped on ack", {3'b0, take_req}, 4'h0);
        ext_lvl = 1'b1; step(2);
        chk("R8 enable cleared by ack", {3'b0, take_req}, 4'h0);
        ext_lvl = 1'b0; step(1);
    endtask

    task automatic t_dec_coalesce();
        dec_pulse(); dec_pulse(); dec_pulse();
        chk("R1 timer flag set", {2'b0, pend}, 4'h2);
        write_en(1'b1);
        chk("R2 timer delivered", {3'b0, take_req}, 4'h1);
        chk("R6 timer cause", {2'b0, cause}, 4'h2);
        do_ack();
        chk("R8 timer flag cleared", {2'b0, pend}, 4'h0);
        write_en(1'b1);
        step(1);
        chk("R2 only one delivery", {3'b0, take_req}, 4'h0);
        write_en(1'b0);
    endtask

    task automatic t_priority();
        dec_pulse();
        ext_lvl = 1'b1;
        write_en(1'b1);
        chk("R6 external wins", {2'b0, cause}, 4'h1);
        chk("R6 both pending", {2'b0, pend}, 4'h3);
        ext_lvl = 1'b0;
        do_ack();
        chk("R8 timer kept after external ack", {2'b0, pend}, 4'h2);
        chk("R8 no take after ack", {3'b0, take_req}, 4'h0);
        write_en(1'b1);
        chk("R6 timer follows", {2'b0, cause}, 4'h2);
        do_ack();
        chk("R8 all clear", {2'b0, pend}, 4'h0);
    endtask

    task automatic t_idle_ack();
        dec_pulse();
        do_ack();
        step(1);
        chk("R9 idle ack leaves flag", {2'b0, pend}, 4'h2);
        chk("R9 idle ack no take", {3'b0, take_req}, 4'h0);
        write_en(1'b1);
        chk("R9 later delivery intact", {2'b0, cause}, 4'h2);
        do_ack();
    endtask

    task automatic t_ack_overrides_write();
        ext_lvl = 1'b1;
        write_en(1'b1);
        chk("R3 external taken", {3'b0, take_req}, 4'h1);
        ext_lvl = 1'b0;
        ack = 1'b1; stat_wr = 1'b1; stat_en = 1'b1;
        step(1);
        ack = 1'b0; stat_wr = 1'b0; stat_en = 1'b0;
        ext_lvl = 1'b1; step(2);
        chk("R8 ack beats status write", {3'b0, take_req}, 4'h0);
        ext_lvl = 1'b0; step(1);
    endtask

    task automatic t_mid_reset();
        dec_pulse();
        rst = 1'b1; step(1); rst = 1'b0; step(1);
        chk("R10 reset clears timer flag", {2'b0, pend}, 4'h0);
        write_en(1'b1);
        chk("R10 nothing to deliver", {3'b0, take_req}, 4'h0);
        write_en(1'b0);
        write_en(1'b1);
        rst = 1'b1; step(1); rst = 1'b0;
        ext_lvl = 1'b1; step(2);
        chk("R10 reset clears enable", {3'b0, take_req}, 4'h0);
        ext_lvl = 1'b0; step(1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_masked_pulse();
        t_ext_deliver();
        t_dec_coalesce();
        t_priority();
        t_idle_ack();
        t_ack_overrides_write();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule